// File: doc/BRIEF.md
# Processor Interrupt Level Arbiter

This block sits in front of a processor core and turns a set of interrupt sources into one trap index. Sixteen external level lines are merged with a software pending register. The software timer flag is moved onto level 14 before the merge. The block picks the highest pending level from 15 down to 1 and registers it as an external-class trap index: upper field 0x4, level in the low four bits. It also drives a hard-interrupt request and a one-cycle wake pulse that pulls a halted core back into execution.

The index register is shared with the core. The core can load a trap code of another class into it. While such a code is present, the arbiter leaves it alone. The arbiter only writes the index when the index is empty or already holds an external-class value. When nothing is pending, the arbiter withdraws its own external index and drops the request. A foreign code is not withdrawn in that case.

Top module: `pil_arbiter`

## Requirements
- R1: A synchronous active-high reset clears the index, the request and the wake pulse to zero.
- R2: The pending vector is the OR of `ext_lvl` and the software bits other than the timer bit (bit 0 of `sw_pend`). The timer bit contributes at level 14. Every other software bit k contributes at level k.
- R3: One cycle after the inputs are sampled, an arbitrating index becomes 0x40 ORed with the highest set pending level in 15..1.
- R4: Pending bit 0 on its own never produces an index. It also does not count as empty: with only bit 0 pending, an external index already held stays unchanged.
- R5: An index whose upper four bits are neither 0 nor 0x4 is never replaced or cleared by the arbiter. It remains until the core loads a new code.
- R6: When `trap_load` is high, `trap_code` is written into the index on the next edge. This takes precedence over arbitration in that cycle.
- R7: `hard_req` rises in the cycle the index takes a new external value. It stays high while the index stays external. It is unaffected by a reload of the same value.
- R8: When the pending vector is all zero and the index is external class, the index returns to 0 and `hard_req` falls on the next edge.
- R9: `wake` pulses for one cycle, one edge after any `ext_lvl` line goes from 0 to 1. A line falling produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_lvl | input | 16 | External interrupt level lines, one per level |
| sw_pend | input | 16 | Software pending bits; bit 0 is the timer flag |
| trap_load | input | 1 | Core writes `trap_code` into the index |
| trap_code | input | 8 | Trap index written by the core |
| irq_idx | output | 8 | Current trap index |
| hard_req | output | 1 | Hard-interrupt request to the core |
| wake | output | 1 | One-cycle pulse ending a halted state |

## Verification
The hardest situations to reach are the ones where the index holds a code the arbiter did not produce. Others are hard because pending bit 0 keeps the vector nonzero without selecting a level. The bench reaches the first through `trap_load` with foreign codes, then toggles the external lines and checks that the index survives both rising and falling pending. It reaches the second by dropping every line except line 0 while an external index is held. Beyond those directed cases, the bench sweeps every pair of external lines and every single software bit. It then runs a long random walk against an arithmetic model kept in the bench.

// File: rtl/pil_arbiter.sv
module pil_arbiter #(
  parameter int NLVL = 16,
  parameter int IDX_W = 8,
  parameter int TIMER_BIT = 0,
  parameter int TIMER_LVL = 14,
  parameter logic [IDX_W-1:0] EXT_CLASS = 8'h40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLVL-1:0]  ext_lvl,
  input  logic [NLVL-1:0]  sw_pend,
  input  logic             trap_load,
  input  logic [IDX_W-1:0] trap_code,
  output logic [IDX_W-1:0] irq_idx,
  output logic             hard_req,
  output logic             wake
);
  localparam int LVL_W = $clog2(NLVL);
  localparam logic [NLVL-1:0] TMR_SRC = NLVL'(1) << TIMER_BIT;
  localparam logic [NLVL-1:0] TMR_DST = NLVL'(1) << TIMER_LVL;

  logic [NLVL-1:0]  pend;
  logic [NLVL-1:0]  ext_q;
  logic [LVL_W-1:0] win;
  logic             any_lvl;
  logic             is_ext;
  logic             may_take;
  logic [IDX_W-1:0] cand;

  assign pend = ext_lvl | (sw_pend & ~TMR_SRC) | (|(sw_pend & TMR_SRC) ? TMR_DST : '0);
  assign any_lvl = |pend[NLVL-1:1];
  assign is_ext = irq_idx[IDX_W-1:LVL_W] == EXT_CLASS[IDX_W-1:LVL_W];
  assign may_take = (irq_idx == '0) || is_ext;

  always_comb begin
    win = '0;
    for (int i = 1; i < NLVL; i++)
      if (pend[i]) win = LVL_W'(i);
  end

  assign cand = {EXT_CLASS[IDX_W-1:LVL_W], win};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_idx  <= '0;
      hard_req <= 1'b0;
      wake     <= 1'b0;
      ext_q    <= '0;
    end else begin
      ext_q <= ext_lvl;
      wake  <= |(ext_lvl & ~ext_q);
      if (trap_load) begin
        irq_idx <= trap_code;
      end else if (pend != '0 && may_take) begin
        if (any_lvl && cand != irq_idx) begin
          irq_idx  <= cand;
          hard_req <= 1'b1;
        end
      end else if (pend == '0 && is_ext) begin
        irq_idx  <= '0;
        hard_req <= 1'b0;
      end
    end
  end

  logic chk_ok;
  always_ff @(posedge clk) chk_ok <= !rst;

  a_r5_foreign_hold: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    ($past(!trap_load) && $past(irq_idx) != '0 &&
     $past(irq_idx[IDX_W-1:LVL_W]) != EXT_CLASS[IDX_W-1:LVL_W]) |-> $stable(irq_idx));

  a_r6_load: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    $past(trap_load) |-> irq_idx == $past(trap_code));

  a_r7_req_on_change: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    $rose(hard_req) |-> (irq_idx != $past(irq_idx) &&
                         irq_idx[IDX_W-1:LVL_W] == EXT_CLASS[IDX_W-1:LVL_W]));

  a_r8_clear: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    ($past(!trap_load) && $past(ext_lvl) == '0 && $past(sw_pend) == '0 &&
     $past(irq_idx[IDX_W-1:LVL_W]) == EXT_CLASS[IDX_W-1:LVL_W]) |-> (irq_idx == '0 && !hard_req));

  a_r9_wake_src: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    wake |-> $past(ext_lvl) != '0);

  a_r3_class: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    ($past(!trap_load) && irq_idx != $past(irq_idx) && irq_idx != '0) |->
      (irq_idx[IDX_W-1:LVL_W] == EXT_CLASS[IDX_W-1:LVL_W] && irq_idx[LVL_W-1:0] != '0));
endmodule

// File: tb/pil_arbiter_tb.sv
module pil_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ext_lvl = '0;
  logic [15:0] sw_pend = '0;
  logic        trap_load = 1'b0;
  logic [7:0]  trap_code = '0;
  logic [7:0]  irq_idx;
  logic        hard_req;
  logic        wake;

  int n_tests = 0;
  int n_fail = 0;

  logic [7:0]  m_idx;
  logic        m_req;
  logic        m_wake;
  logic [15:0] m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  pil_arbiter dut_i (
    .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .sw_pend(sw_pend),
    .trap_load(trap_load), .trap_code(trap_code),
    .irq_idx(irq_idx), .hard_req(hard_req), .wake(wake)
  );

  task automatic chk(input string tag, input logic [7:0] ai, input logic [7:0] ei,
                     input logic ar, input logic er, input logic aw, input logic ew);
    n_tests++;
    if (ai !== ei || ar !== er || aw !== ew) begin
      n_fail++;
      $display("FAIL %s: idx/req/wake actual %h/%b/%b expected %h/%b/%b",
               tag, ai, ar, aw, ei, er, ew);
    end
  endtask

  task automatic step(input string tag, input logic [15:0] e, input logic [15:0] s,
                      input logic tl, input logic [7:0] tc);
    logic [15:0] p;
    int top;
    @(negedge clk);
    ext_lvl = e; sw_pend = s; trap_load = tl; trap_code = tc;
    p = e | (s & 16'hFFFE) | (s[0] ? 16'h4000 : 16'h0000);
    top = 0;
    for (int i = 1; i < 16; i++) if (p[i]) top = i;
    m_wake = |(e & ~m_prev);
    m_prev = e;
    if (tl) m_idx = tc;
    else if (p != 0 && (m_idx == 0 || m_idx[7:4] == 4'h4)) begin
      if (top != 0 && (8'h40 | 8'(top)) != m_idx) begin
        m_idx = 8'h40 | 8'(top);
        m_req = 1'b1;
      end
    end else if (p == 0 && m_idx[7:4] == 4'h4) begin
      m_idx = 0; m_req = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, irq_idx, m_idx, hard_req, m_req, wake, m_wake);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_idx = 0; m_req = 0; m_wake = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset", irq_idx, 8'h00, hard_req, 1'b0, wake, 1'b0);

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        step("R3 pair", 16'(1 << a) | 16'(1 << b), 16'h0, 1'b0, 8'h0);
        step("R8 drop", 16'h0, 16'h0, 1'b0, 8'h0);
      end

    for (int k = 0; k < 16; k++) begin
      step("R2 swbit", 16'h0, 16'(1 << k), 1'b0, 8'h0);
      step("R8 swclr", 16'h0, 16'h0, 1'b0, 8'h0);
    end
    step("R2 timer+l13", 16'h2000, 16'h0001, 1'b0, 8'h0);
    step("R2 timer+l15", 16'h8000, 16'h0001, 1'b0, 8'h0);
    step("R7 samelvl", 16'h8000, 16'h0000, 1'b0, 8'h0);
    step("R9 nofall", 16'h0000, 16'h8000, 1'b0, 8'h0);
    step("R8 clr", 16'h0, 16'h0, 1'b0, 8'h0);

    step("R4 bit0 empty", 16'h0001, 16'h0, 1'b0, 8'h0);
    step("R4 lvl5", 16'h0021, 16'h0, 1'b0, 8'h0);
    step("R4 bit0 hold", 16'h0001, 16'h0, 1'b0, 8'h0);
    step("R8 clr2", 16'h0, 16'h0, 1'b0, 8'h0);

    step("R6 load", 16'h0, 16'h0, 1'b1, 8'h23);
    step("R5 rise", 16'h0400, 16'h0, 1'b0, 8'h0);
    step("R5 fall", 16'h0000, 16'h0, 1'b0, 8'h0);
    step("R6 prio", 16'h8000, 16'h0, 1'b1, 8'h00);
    step("R3 after", 16'h8000, 16'h0, 1'b0, 8'h0);
    step("R6 extload", 16'h8000, 16'h0, 1'b1, 8'h4F);
    step("R7 same", 16'h8000, 16'h0, 1'b0, 8'h0);

    for (int n = 0; n < 4000; n++) begin
      logic [15:0] e, s;
      logic tl;
      e = 16'($urandom) & 16'($urandom) & 16'($urandom);
      s = ($urandom % 4 == 0) ? 16'($urandom) & 16'($urandom) : 16'h0;
      if ($urandom % 3 == 0) begin e = 0; s = 0; end
      tl = ($urandom % 16 == 0);
      step("R3 rand", e, s, tl, 8'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule